// File: doc/BRIEF.md
# Window Hysteresis Alarm Output

This block turns a stream of 8-bit measurement results for one channel into an alarm that drives an open-drain pin. Each result is compared against an upper and a lower limit supplied from outside. The comparison takes effect a fixed number of slow conversion-clock pulses after the result arrives, so the pin moves at a known point in the conversion schedule.

The block has two modes. In comparator mode the alarm behaves like a thermostat with hysteresis. It switches on at or above the upper limit, switches off at or below the lower limit, and holds its state anywhere in between. In interrupt mode the alarm latches whenever that hysteresis state flips, in either direction, and stays latched until the host reads the channel. A read does not re-arm the alarm; only a fresh flip sets it again.

A polarity input chooses whether the active alarm level is low or high at the pin. A shutdown input freezes the comparison and drops any latched interrupt. A configuration reset input clears everything and forces the alarm inactive.

Top module: `win_alarm`

## Requirements
- R1: After the synchronous active-high `rst`, `alarm` is 0, any pending result is discarded, and `od_pull_low` equals `pol_high`.
- R2: In comparator mode (`mode_int`=0), when an update is applied, a result >= `lim_hi` makes `alarm` 1. Otherwise a result <= `lim_lo` makes it 0. Otherwise `alarm` keeps its value. The upper test takes priority, and both bounds are inclusive.
- R3: A result is captured in a cycle with `res_valid`=1. It is applied at the clock edge of the 10th later cycle with `tick`=1, and a tick in the capture cycle is not counted. `alarm` is unchanged before that edge and shows the update in the cycle after it.
- R4: A new `res_valid` while a result is still pending replaces that result and restarts the tick count from zero.
- R5: In interrupt mode (`mode_int`=1), `alarm` is an interrupt flag. An update that flips the hysteresis state of R2, upward or downward, sets the flag.
- R6: `rd_clr`=1 clears the interrupt flag at that edge. Later updates that do not flip the hysteresis state leave it clear. If an update with a flip falls in the same cycle as a read, the set wins.
- R7: While `shutdown`=1, `res_valid` is ignored and any pending result is discarded. The hysteresis state, and so the comparator-mode `alarm`, holds, and the interrupt flag is cleared.
- R8: `cfg_reset`=1 clears the hysteresis state, the interrupt flag and any pending result at the next edge. `res_valid` is ignored while it is high, and `alarm` is 0 from the cycle after it is first seen.
- R9: `od_pull_low` = `alarm` XOR `pol_high` and follows `pol_high` in the same cycle. With `pol_high`=0 (active low) an active alarm pulls the pin low. With `pol_high`=1 (active high) an inactive alarm pulls it low.
- R10: The hysteresis state is tracked in both modes. Changing `mode_int` changes which of the two states `alarm` shows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also used for the external stop/reset pin |
| tick | input | 1 | One-cycle pulse per conversion clock period |
| res_valid | input | 1 | Conversion result strobe for this channel |
| res_data | input | 8 | Conversion result |
| lim_hi | input | 8 | Upper limit |
| lim_lo | input | 8 | Lower limit |
| mode_int | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol_high | input | 1 | 0 active-low pin, 1 active-high pin |
| rd_clr | input | 1 | Host read of this channel, clears the interrupt flag |
| shutdown | input | 1 | Freeze comparison, clear interrupt flag |
| cfg_reset | input | 1 | Configuration reset, clears all state |
| alarm | output | 1 | Logical alarm level |
| od_pull_low | output | 1 | Open-drain pull-down enable |

## Verification
A result's effect on `alarm` is due in the cycle after the edge that samples the 10th tick following the capture. The bench therefore checks once after the 9th tick, expecting the old value, and again after the 10th, expecting the new one. Reads, shutdown and configuration reset are checked one cycle after the edge that samples them. Polarity and mode selection are checked in the same cycle, shortly after the input changes. All ports are driven and sampled on the falling clock edge, so each sample falls between two rising edges.

// File: rtl/win_alarm_pkg.sv
package win_alarm_pkg;

    // Position of a result relative to the two limits
    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_MID  = 2'd1,
        ZONE_HIGH = 2'd2
    } zone_e;

    typedef enum logic {
        MODE_COMP = 1'b0,
        MODE_INT  = 1'b1
    } alarm_mode_e;

    // Hysteresis state plus latched interrupt flag
    typedef struct packed {
        logic hyst;
        logic intr;
    } alarm_state_t;

    localparam int DEFAULT_DELAY_TICKS = 10;

    // Next thermostat state given the zone of the new result
    function automatic logic next_hyst(input zone_e z, input logic cur);
        case (z)
            ZONE_HIGH: next_hyst = 1'b1;
            ZONE_LOW:  next_hyst = 1'b0;
            default:   next_hyst = cur;
        endcase
    endfunction

endpackage

// File: rtl/win_alarm_window.sv
module win_alarm_window
    import win_alarm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    output zone_e             zone
);

    // Upper limit is tested first so overlapping limits resolve high
    always_comb begin
        if (sample >= lim_hi)      zone = ZONE_HIGH;
        else if (sample <= lim_lo) zone = ZONE_LOW;
        else                       zone = ZONE_MID;
    end

endmodule

// File: rtl/win_alarm_delay.sv
module win_alarm_delay #(
    parameter int DATA_W      = 8,
    parameter int DELAY_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              capture,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tick,
    output logic              fire,
    output logic [DATA_W-1:0] data_out
);

    localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    // The last tick of the window applies the held result
    assign fire = pend_q && tick && (cnt_q == LAST) && !capture && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            data_out <= '0;
        end else if (flush) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (capture) begin
            pend_q   <= 1'b1;
            cnt_q    <= '0;
            data_out <= data_in;
        end else if (pend_q && tick) begin
            if (cnt_q == LAST) begin
                pend_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/win_alarm_state.sv
module win_alarm_state
    import win_alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_all,
    input  logic         freeze,
    input  logic         fire,
    input  zone_e        zone,
    input  logic         rd_clr,
    output alarm_state_t st
);

    logic nh;
    logic flip;

    assign nh   = next_hyst(zone, st.hyst);
    assign flip = fire && (nh != st.hyst);

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            st <= '0;
        end else if (freeze) begin
            st.intr <= 1'b0;
        end else begin
            if (fire)        st.hyst <= nh;
            if (flip)        st.intr <= 1'b1;
            else if (rd_clr) st.intr <= 1'b0;
        end
    end

endmodule

// File: rtl/win_alarm.sv
module win_alarm
    import win_alarm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DELAY_TICKS = DEFAULT_DELAY_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    input  logic              mode_int,
    input  logic              pol_high,
    input  logic              rd_clr,
    input  logic              shutdown,
    input  logic              cfg_reset,
    output logic              alarm,
    output logic              od_pull_low
);

    logic              upd;
    logic [DATA_W-1:0] held;
    zone_e             zone;
    alarm_state_t      st;
    alarm_mode_e       mode;
    logic              hyst_q;
    logic              intr_q;

    win_alarm_delay #(
        .DATA_W      (DATA_W),
        .DELAY_TICKS (DELAY_TICKS)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .flush    (shutdown || cfg_reset),
        .capture  (res_valid),
        .data_in  (res_data),
        .tick     (tick),
        .fire     (upd),
        .data_out (held)
    );

    win_alarm_window #(
        .DATA_W (DATA_W)
    ) u_window (
        .sample (held),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .zone   (zone)
    );

    win_alarm_state u_state (
        .clk       (clk),
        .rst       (rst),
        .clear_all (cfg_reset),
        .freeze    (shutdown),
        .fire      (upd),
        .zone      (zone),
        .rd_clr    (rd_clr),
        .st        (st)
    );

    assign hyst_q = st.hyst;
    assign intr_q = st.intr;
    assign mode   = alarm_mode_e'(mode_int);

    always_comb begin
        case (mode)
            MODE_INT: alarm = intr_q;
            default:  alarm = hyst_q;
        endcase
    end

    // Pin pulled low when the logical level differs from the polarity bit
    assign od_pull_low = alarm ^ pol_high;

endmodule

// File: rtl/win_alarm_checks.sv
module win_alarm_checks #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_clr,
    input logic              shutdown,
    input logic              cfg_reset,
    input logic              upd,
    input logic [DATA_W-1:0] held,
    input logic [DATA_W-1:0] lim_hi,
    input logic [DATA_W-1:0] lim_lo,
    input logic              hyst_q,
    input logic              intr_q,
    input logic              alarm
);

    // R2
    upper_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && held >= lim_hi) |=> hyst_q);

    // R2
    lower_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && held < lim_hi && held <= lim_lo) |=> !hyst_q);

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd && !rd_clr && !shutdown && !cfg_reset) |=> ($stable(hyst_q) && $stable(intr_q)));

    // R5
    flip_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && held >= lim_hi && !hyst_q) |=> intr_q);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !upd) |=> !intr_q);

    // R7
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (shutdown && !cfg_reset) |=> ($stable(hyst_q) && !intr_q));

    // R8
    cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_reset |=> (!alarm && !hyst_q && !intr_q));

endmodule

bind win_alarm win_alarm_checks #(.DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .rd_clr    (rd_clr),
    .shutdown  (shutdown),
    .cfg_reset (cfg_reset),
    .upd       (upd),
    .held      (held),
    .lim_hi    (lim_hi),
    .lim_lo    (lim_lo),
    .hyst_q    (hyst_q),
    .intr_q    (intr_q),
    .alarm     (alarm)
);

// File: tb/tb_win_alarm.sv
module tb_win_alarm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       res_valid = 1'b0;
    logic [7:0] res_data = 8'h00;
    logic [7:0] lim_hi = 8'h80;
    logic [7:0] lim_lo = 8'h66;
    logic       mode_int = 1'b0;
    logic       pol_high = 1'b0;
    logic       rd_clr = 1'b0;
    logic       shutdown = 1'b0;
    logic       cfg_reset = 1'b0;
    logic       alarm;
    logic       od_pull_low;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    win_alarm dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .lim_hi      (lim_hi),
        .lim_lo      (lim_lo),
        .mode_int    (mode_int),
        .pol_high    (pol_high),
        .rd_clr      (rd_clr),
        .shutdown    (shutdown),
        .cfg_reset   (cfg_reset),
        .alarm       (alarm),
        .od_pull_low (od_pull_low)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; res_valid = 1'b0; rd_clr = 1'b0;
        shutdown = 1'b0; cfg_reset = 1'b0; mode_int = 1'b0; pol_high = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        res_valid = 1'b1; res_data = d;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic full(input logic [7:0] d);
        send(d);
        ticks(10);
    endtask

    task automatic read_pulse();
        @(negedge clk); rd_clr = 1'b1;
        @(negedge clk); rd_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "alarm after reset", alarm, 1'b0);
        chk("R1", "pin after reset pol0", od_pull_low, 1'b0);
        pol_high = 1'b1; #1;
        chk("R1", "pin after reset pol1", od_pull_low, 1'b1);
        pol_high = 1'b0;
    endtask

    task automatic t_comparator();
        do_reset();
        send(8'h90);
        ticks(9);
        chk("R3", "unchanged after 9 ticks", alarm, 1'b0);
        ticks(1);
        chk("R3", "updated on 10th tick", alarm, 1'b1);
        chk("R9", "active low pulls pin", od_pull_low, 1'b1);
        full(8'h70);
        chk("R2", "between limits holds high", alarm, 1'b1);
        full(8'h67);
        chk("R2", "one above lower holds", alarm, 1'b1);
        full(8'h66);
        chk("R2", "equal lower clears", alarm, 1'b0);
        full(8'h7F);
        chk("R2", "one below upper holds low", alarm, 1'b0);
        full(8'h80);
        chk("R2", "equal upper sets", alarm, 1'b1);
    endtask

    task automatic t_restart();
        do_reset();
        full(8'h90);
        send(8'h10);
        ticks(5);
        send(8'h20);
        ticks(5);
        chk("R4", "restart ignores first window", alarm, 1'b1);
        ticks(4);
        chk("R4", "9 ticks after replacement", alarm, 1'b1);
        ticks(1);
        chk("R4", "replacement applied", alarm, 1'b0);
    endtask

    task automatic t_interrupt();
        do_reset();
        mode_int = 1'b1;
        full(8'h90);
        chk("R5", "upward flip sets flag", alarm, 1'b1);
        read_pulse();
        chk("R6", "read clears flag", alarm, 1'b0);
        full(8'hA0);
        chk("R6", "no re-arm without flip", alarm, 1'b0);
        full(8'h50);
        chk("R5", "downward flip sets flag", alarm, 1'b1);
        read_pulse();
        chk("R6", "second read clears", alarm, 1'b0);
        send(8'h90);
        ticks(9);
        @(negedge clk); tick = 1'b1; rd_clr = 1'b1;
        @(negedge clk); tick = 1'b0; rd_clr = 1'b0;
        chk("R6", "set wins over same-cycle read", alarm, 1'b1);
        read_pulse();
        @(negedge clk); mode_int = 1'b0; #1;
        chk("R10", "comparator view after switch", alarm, 1'b1);
        mode_int = 1'b1; #1;
        chk("R10", "interrupt view after switch back", alarm, 1'b0);
    endtask

    task automatic t_shutdown();
        do_reset();
        full(8'h90);
        @(negedge clk); shutdown = 1'b1;
        send(8'h10);
        ticks(10);
        chk("R7", "comparator holds in shutdown", alarm, 1'b1);
        @(negedge clk); shutdown = 1'b0;
        ticks(10);
        chk("R7", "result during shutdown ignored", alarm, 1'b1);
        send(8'h10);
        ticks(5);
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk); shutdown = 1'b0;
        ticks(10);
        chk("R7", "pending result discarded", alarm, 1'b1);
        do_reset();
        mode_int = 1'b1;
        full(8'h90);
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk); shutdown = 1'b0;
        chk("R7", "shutdown clears flag", alarm, 1'b0);
    endtask

    task automatic t_cfg_reset();
        do_reset();
        full(8'h90);
        @(negedge clk); cfg_reset = 1'b1;
        @(negedge clk);
        chk("R8", "config reset forces inactive", alarm, 1'b0);
        send(8'h90);
        @(negedge clk); pol_high = 1'b1; #1;
        chk("R9", "active high idle pulls pin", od_pull_low, 1'b1);
        @(negedge clk); cfg_reset = 1'b0; pol_high = 1'b0;
        ticks(10);
        chk("R8", "result during config reset ignored", alarm, 1'b0);
    endtask

    task automatic t_polarity();
        do_reset();
        full(8'h90);
        @(negedge clk); pol_high = 1'b1; #1;
        chk("R9", "active high alarm releases pin", od_pull_low, 1'b0);
        pol_high = 1'b0; #1;
        chk("R9", "active low alarm pulls pin", od_pull_low, 1'b1);
    endtask

    initial begin
        t_reset();
        t_comparator();
        t_restart();
        t_interrupt();
        t_shutdown();
        t_cfg_reset();
        t_polarity();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule